// File: doc/BRIEF.md
# Ethernet Transmit Error Status Logic

This block follows one outgoing Ethernet frame at a time and decides how it ends. It sees the frame open and close, and it watches for four failure kinds: the transmit FIFO running dry, the retry budget being spent, a collision arriving too late, and carrier sense dropping in half-duplex operation. It also checks for a heartbeat: after a frame, a working transceiver answers with a short collision pulse. From these inputs the block derives the status bits that the MAC writes into the frame's last transmit descriptor.

Each failure kind has its own reaction. A FIFO underrun makes the block first command a 32-bit tail that guarantees a bad CRC, and only then stop the frame. A spent retry budget or a late collision stops the frame at once. In all three cases the block asks for the frame's remaining buffers to be flushed and for the next descriptor to be started. A carrier loss only marks the frame; the frame still completes. A missing heartbeat marks the frame and can raise an interrupt. When the frame closes, the status word is presented together with a single-cycle valid strobe.

Top module: `eth_tx_err_status`

## Requirements
- R1: A `fifo_underrun` sampled during a frame drives `force_bad_crc` high for exactly JAM_BITS/TX_BITS_PER_CLK cycles (8 by default), starting the cycle after. In the next cycle `status_valid`, `st_un`, `stop_tx`, `flush_bufs` and `skip_next` are all 1 and `force_bad_crc` is 0.
- R2: In half duplex, when `carrier_sense` is low for any sampled cycle of a frame and no collision occurs in that frame, `st_csl` is 1 at close. The frame still closes normally, with `stop_tx`, `flush_bufs` and `skip_next` at 0.
- R3: With `full_duplex` = 1, `st_csl` stays 0 whatever the level of `carrier_sense`.
- R4: If `collision` is sampled high during the frame, `st_csl` is 0 at close even when carrier sense dropped.
- R5: `retry_limit` sampled during a frame closes it in the following cycle with `st_rl`, `stop_tx`, `flush_bufs` and `skip_next` all at 1.
- R6: `late_coll` sampled during a frame closes it in the following cycle with `st_lc`, `stop_tx`, `flush_bufs` and `skip_next` all at 1.
- R7: With `hb_check_en` = 1, a `collision` sampled on cycle k (1 to 20) after the `frame_end` edge closes the frame one cycle later with `st_hb` = 0.
- R8: With `hb_check_en` = 1 and no collision in the 20 cycles after `frame_end`, the frame closes after cycle 20 with `st_hb` = 1. `hb_irq` pulses at that moment exactly when `hb_irq_en` = 1.
- R9: With `hb_check_en` = 0, `status_valid` is 1 in the cycle after the `frame_end` edge and `st_hb` is 0.
- R10: When several abort causes are present, the priority is underrun over retry limit over late collision, and exactly one of `st_un`, `st_rl`, `st_lc` is set. An aborted frame never sets `st_csl` or `st_hb` and does not wait for a heartbeat.
- R11: A `frame_start` given in the same cycle as the `status_valid` of an aborted frame is accepted.
- R12: After reset, every output is 0. All status bits read 0 in the cycle after an accepted `frame_start`, and `status_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | A new frame begins (accepted while idle) |
| frame_end | input | 1 | Last bit of the frame has been sent |
| fifo_underrun | input | 1 | Transmit FIFO ran dry |
| carrier_sense | input | 1 | Carrier present on the medium |
| collision | input | 1 | Collision indication from the transceiver |
| retry_limit | input | 1 | Retry budget exhausted |
| late_coll | input | 1 | Collision after the allowed window |
| full_duplex | input | 1 | Full-duplex operation |
| hb_check_en | input | 1 | Enables the post-frame heartbeat check |
| hb_irq_en | input | 1 | Enables the heartbeat-error interrupt |
| force_bad_crc | output | 1 | Send the CRC-corrupting tail |
| stop_tx | output | 1 | Pulse: stop transmitting this frame |
| flush_bufs | output | 1 | Pulse: flush the frame's remaining buffers |
| skip_next | output | 1 | Pulse: continue with the next descriptor |
| status_valid | output | 1 | Pulse: status bits are final |
| st_un | output | 1 | Underrun status |
| st_csl | output | 1 | Carrier-lost status |
| st_rl | output | 1 | Retry-limit status |
| st_lc | output | 1 | Late-collision status |
| st_hb | output | 1 | Heartbeat-error status |
| hb_irq | output | 1 | Pulse: heartbeat-error interrupt |

## Verification
All results are registered, and each is due a fixed number of cycles after its cause. An abort by retry limit or late collision, or a normal close without heartbeat check, shows `status_valid` one cycle after the sampling edge. An underrun shows `force_bad_crc` for eight cycles and then the status. A heartbeat close comes one cycle after the answering collision, or after window cycle 20. The bench drives inputs at the falling edge and samples right after each rising edge. Around a close it checks `status_valid` in every cycle, so the pulse must appear in exactly the predicted cycle and in no other. It sweeps duplex mode, carrier drop, in-frame collision, heartbeat enable, interrupt enable and heartbeat delays across and just past the window, plus every combination of the abort causes.

// File: rtl/eth_txerr_pkg.sv
package eth_txerr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_JAM  = 2'd2,
    ST_HBW  = 2'd3
  } txe_state_e;

  typedef struct packed {
    logic un;
    logic csl;
    logic rl;
    logic lc;
    logic hb;
  } txe_status_t;

endpackage

// File: rtl/txe_win_cnt.sv
// Up counter for a fixed window; flags its last step.
module txe_win_cnt #(
  parameter int LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST_V = W'(LEN - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == LAST_V);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && !last)   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1 and R8 windows rely on the count never passing its last step
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);

endmodule

// File: rtl/txe_csl_track.sv
// Tracks carrier loss and in-frame collisions for the current frame.
module txe_csl_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sample,
  input  logic carrier_sense,
  input  logic collision,
  input  logic full_duplex,
  output logic csl_now
);
  logic lost_q, lost_d;
  logic coll_q, coll_d;
  logic lost_hit, coll_hit;

  assign lost_hit = sample && !carrier_sense && !full_duplex;
  assign coll_hit = sample && collision;
  assign csl_now  = (lost_q || lost_hit) && !(coll_q || coll_hit);

  always_comb begin
    lost_d = lost_q;
    coll_d = coll_q;
    if (clr) begin
      lost_d = 1'b0;
      coll_d = 1'b0;
    end else begin
      if (lost_hit) lost_d = 1'b1;
      if (coll_hit) coll_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      lost_q <= lost_d;
      coll_q <= coll_d;
    end
  end

  // R3: a carrier loss is never recorded in full duplex
  p_no_loss_fd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(!full_duplex && sample));

endmodule

// File: rtl/eth_tx_err_status.sv
module eth_tx_err_status
  import eth_txerr_pkg::*;
#(
  parameter int JAM_BITS        = 32,
  parameter int TX_BITS_PER_CLK = 4,
  parameter int HB_WINDOW       = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic frame_end,
  input  logic fifo_underrun,
  input  logic carrier_sense,
  input  logic collision,
  input  logic retry_limit,
  input  logic late_coll,
  input  logic full_duplex,
  input  logic hb_check_en,
  input  logic hb_irq_en,
  output logic force_bad_crc,
  output logic stop_tx,
  output logic flush_bufs,
  output logic skip_next,
  output logic status_valid,
  output logic st_un,
  output logic st_csl,
  output logic st_rl,
  output logic st_lc,
  output logic st_hb,
  output logic hb_irq
);
  localparam int JAM_CYC = JAM_BITS / TX_BITS_PER_CLK;

  txe_state_e  st_q, st_d;
  txe_status_t stat_q, stat_d;
  logic sv_q, sv_d, stop_q, stop_d, irq_q, irq_d;
  logic jam_clr, jam_en, jam_last;
  logic hb_clr, hb_en, hb_last;
  logic trk_clr, csl_now;

  txe_win_cnt #(.LEN(JAM_CYC)) u_jam_cnt (
    .clk(clk), .rst_n(rst_n), .clr(jam_clr), .en(jam_en), .last(jam_last)
  );

  txe_win_cnt #(.LEN(HB_WINDOW)) u_hb_cnt (
    .clk(clk), .rst_n(rst_n), .clr(hb_clr), .en(hb_en), .last(hb_last)
  );

  txe_csl_track u_csl (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .sample(st_q == ST_SEND),
    .carrier_sense(carrier_sense), .collision(collision),
    .full_duplex(full_duplex), .csl_now(csl_now)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    stat_d  = stat_q;
    sv_d    = 1'b0;
    stop_d  = 1'b0;
    irq_d   = 1'b0;
    jam_clr = 1'b0;
    jam_en  = 1'b0;
    hb_clr  = 1'b0;
    hb_en   = 1'b0;
    trk_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_start) begin
          st_d    = ST_SEND;
          stat_d  = '0;
          trk_clr = 1'b1;
        end
      end
      ST_SEND: begin
        if (fifo_underrun) begin
          st_d      = ST_JAM;
          stat_d.un = 1'b1;
          jam_clr   = 1'b1;
        end else if (retry_limit) begin
          st_d      = ST_IDLE;
          stat_d.rl = 1'b1;
          sv_d      = 1'b1;
          stop_d    = 1'b1;
        end else if (late_coll) begin
          st_d      = ST_IDLE;
          stat_d.lc = 1'b1;
          sv_d      = 1'b1;
          stop_d    = 1'b1;
        end else if (frame_end) begin
          stat_d.csl = csl_now;
          if (hb_check_en) begin
            st_d   = ST_HBW;
            hb_clr = 1'b1;
          end else begin
            st_d = ST_IDLE;
            sv_d = 1'b1;
          end
        end
      end
      ST_JAM: begin
        jam_en = 1'b1;
        if (jam_last) begin
          st_d   = ST_IDLE;
          sv_d   = 1'b1;
          stop_d = 1'b1;
        end
      end
      ST_HBW: begin
        hb_en = 1'b1;
        if (collision) begin
          st_d = ST_IDLE;
          sv_d = 1'b1;
        end else if (hb_last) begin
          st_d      = ST_IDLE;
          stat_d.hb = 1'b1;
          sv_d      = 1'b1;
          irq_d     = hb_irq_en;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stat_q <= '0;
      sv_q   <= 1'b0;
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      sv_q   <= sv_d;
      stop_q <= stop_d;
      irq_q  <= irq_d;
    end
  end

  assign force_bad_crc = (st_q == ST_JAM);
  assign stop_tx       = stop_q;
  assign flush_bufs    = stop_q;
  assign skip_next     = stop_q;
  assign status_valid  = sv_q;
  assign st_un         = stat_q.un;
  assign st_csl        = stat_q.csl;
  assign st_rl         = stat_q.rl;
  assign st_lc         = stat_q.lc;
  assign st_hb         = stat_q.hb;
  assign hb_irq        = irq_q;

  // R1: the corrupting tail ends exactly when the underrun status closes
  p_jam_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_bad_crc) |-> (status_valid && st_un && stop_tx));

  // R10: an aborted frame carries one abort cause and no CSL or HB
  p_abort_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && (st_un || st_rl || st_lc)) |->
      ($onehot({st_un, st_rl, st_lc}) && !st_csl && !st_hb));

  // R8: the interrupt appears only with a closing heartbeat error
  p_hb_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hb_irq |-> (status_valid && st_hb));

  // R12: an accepted start leaves all status bits cleared
  p_start_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && frame_start) |=> !(st_un || st_csl || st_rl || st_lc || st_hb));

  // R12: the valid strobe lasts one cycle
  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid);

endmodule

// File: tb/eth_tx_err_status_test.sv
`timescale 1ns/1ps
module eth_tx_err_status_test;
  localparam int HB  = 20;
  localparam int JAM = 32 / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, frame_end = 0, fifo_underrun = 0, carrier_sense = 1;
  logic collision = 0, retry_limit = 0, late_coll = 0, full_duplex = 0;
  logic hb_check_en = 0, hb_irq_en = 0;
  logic force_bad_crc, stop_tx, flush_bufs, skip_next, status_valid;
  logic st_un, st_csl, st_rl, st_lc, st_hb, hb_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eth_tx_err_status uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .fifo_underrun(fifo_underrun), .carrier_sense(carrier_sense),
    .collision(collision), .retry_limit(retry_limit), .late_coll(late_coll),
    .full_duplex(full_duplex), .hb_check_en(hb_check_en), .hb_irq_en(hb_irq_en),
    .force_bad_crc(force_bad_crc), .stop_tx(stop_tx), .flush_bufs(flush_bufs),
    .skip_next(skip_next), .status_valid(status_valid), .st_un(st_un),
    .st_csl(st_csl), .st_rl(st_rl), .st_lc(st_lc), .st_hb(st_hb), .hb_irq(hb_irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] stat_word();
    return {st_un, st_csl, st_rl, st_lc, st_hb};
  endfunction

  task automatic open_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check("R12", "status cleared after start", 32'(stat_word()), 0);
    check("R11", "no valid after start", 32'(status_valid), 0);
  endtask

  task automatic run_normal(input bit fd, input bit cs_drop, input bit coll,
                            input bit hbchk, input bit irqen, input int hbd);
    bit exp_hb, exp_csl;
    int close_k;
    string csl_req;
    full_duplex = fd;
    hb_check_en = hbchk;
    hb_irq_en   = irqen;
    open_frame();
    carrier_sense = !cs_drop;
    collision     = coll;
    @(negedge clk);
    carrier_sense = 1'b1;
    collision     = 1'b0;
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    exp_csl = cs_drop && !fd && !coll;
    exp_hb  = 1'b0;
    if (!hbchk) begin
      check("R9", "valid one cycle after end", 32'(status_valid), 1);
    end else begin
      close_k = (hbd >= 1 && hbd <= HB) ? hbd : HB;
      exp_hb  = !(hbd >= 1 && hbd <= HB);
      for (int k = 1; k <= HB; k++) begin
        collision = (k == hbd);
        @(negedge clk);
        collision = 1'b0;
        check(exp_hb ? "R8" : "R7", "valid timing in window",
              32'(status_valid), 32'(k == close_k));
        if (k == close_k) break;
      end
    end
    csl_req = fd ? "R3" : (coll ? "R4" : "R2");
    check(csl_req, "csl", 32'(st_csl), 32'(exp_csl));
    check(hbchk ? "R8" : "R9", "hb", 32'(st_hb), 32'(exp_hb));
    check("R8", "hb_irq", 32'(hb_irq), 32'(exp_hb && irqen));
    check("R2", "no stop/flush/skip", 32'({stop_tx, flush_bufs, skip_next}), 0);
    check("R2", "no abort bits", 32'({st_un, st_rl, st_lc}), 0);
    @(negedge clk);
    check("R12", "valid pulse ends", 32'(status_valid), 0);
  endtask

  task automatic run_abort(input bit un, input bit rl, input bit lc, input bit hbchk);
    bit eun, erl, elc;
    string req;
    full_duplex = 1'b0;
    hb_check_en = hbchk;
    hb_irq_en   = 1'b1;
    open_frame();
    carrier_sense = 1'b0;
    @(negedge clk);
    carrier_sense = 1'b1;
    fifo_underrun = un;
    retry_limit   = rl;
    late_coll     = lc;
    @(negedge clk);
    fifo_underrun = 1'b0;
    retry_limit   = 1'b0;
    late_coll     = 1'b0;
    eun = un;
    erl = rl && !un;
    elc = lc && !un && !rl;
    req = un ? "R1" : (rl ? "R5" : "R6");
    if (un) begin
      for (int j = 0; j < JAM; j++) begin
        check("R1", "bad crc tail active", 32'(force_bad_crc), 1);
        check("R1", "no valid during tail", 32'(status_valid), 0);
        @(negedge clk);
      end
    end
    check(req, "valid at abort close", 32'(status_valid), 1);
    check("R1", "tail released", 32'(force_bad_crc), 0);
    check("R10", "abort cause priority", 32'({st_un, st_rl, st_lc}),
          32'({eun, erl, elc}));
    check("R10", "no csl/hb on abort", 32'({st_csl, st_hb, hb_irq}), 0);
    check(req, "stop/flush/skip", 32'({stop_tx, flush_bufs, skip_next}), 32'd7);
    // the next frame begins in this very cycle (R11)
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "reset outputs", 32'({force_bad_crc, stop_tx, flush_bufs, skip_next,
          status_valid, stat_word(), hb_irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "idle after reset", 32'({force_bad_crc, status_valid, stat_word()}), 0);

    for (int fd = 0; fd < 2; fd++)
      for (int cs = 0; cs < 2; cs++)
        for (int co = 0; co < 2; co++)
          run_normal(fd[0], cs[0], co[0], 1'b0, 1'b0, 0);

    for (int ie = 0; ie < 2; ie++)
      for (int cs = 0; cs < 2; cs++)
        for (int d = 0; d <= HB + 2; d++)
          run_normal(1'b0, cs[0], 1'b0, 1'b1, ie[0], d);

    for (int hc = 0; hc < 2; hc++)
      for (int m = 1; m < 8; m++) begin
        run_abort(m[2], m[1], m[0], hc[0]);
        run_normal(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      end

    run_abort(1'b1, 1'b0, 1'b0, 1'b1);
    run_normal(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule